// File: doc/BRIEF.md
# Delta-Sigma ADC Conversion Sequencer

This block drives a 22-bit delta-sigma converter whose serial link only carries data towards the host: there is a chip-select output, a serial clock output and a single data input. Each conversion is a fixed sequence. The block holds chip select low for a programmed number of cycles with the clock parked, which starts the conversion. It then releases chip select for a programmed conversion time. Finally it lowers chip select again and clocks in the result. The number of bits read depends on the clock polarity. With the clock idling low, the converter puts a data-ready flag in front of the 24-bit word, so 25 bits are read. With the clock idling high, 24 bits are read.

The 24-bit word uses a non-standard sign scheme. The block turns it into a signed 32-bit value. A code that reports overrange and underrange at the same time cannot be valid, so it produces an error pulse and no result. A converter that failed to leave shutdown returns all ones, and that pattern lands in this error case.

Leaving reset, the block runs two conversions on its own, one straight after the other, to pull a converter out of a stuck shutdown state. It reports nothing from these two runs and only then declares itself ready. After that, a single-cycle start request launches one conversion.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is held, csn_o is 1, sclk_o sits at the idle polarity, valid_o and err_o are 0 and ready_o is 0.
- R2: A start accepted in the idle state makes csn_o low for exactly CS_PULSE_CYCLES cycles with sclk_o idle. csn_o is then high for exactly CONV_CYCLES cycles before the read begins. While the block is idle, csn_o stays high.
- R3: During the read, csn_o is low for exactly NB*2*SCLK_HALF cycles and sclk_o gives NB rising edges, where NB is 25 when CPOL=0 and 24 when CPOL=1. Whenever csn_o is high, sclk_o equals CPOL.
- R4: miso_i is sampled on each rising sclk_o edge, most significant bit first. The data word is the last 24 bits received, so with CPOL=0 the leading flag bit is discarded.
- R5: When data bits 23 and 22 are both 0, result_o holds bits 21:0 of the word. Bits 31:22 are copies of bit 21, either all ones or all zeros.
- R6: When bit 22 is 1 and bit 23 is 0 (overrange), bit 22 is dropped, result_o[21:0] is the data and result_o[31:22] is zero.
- R7: When bit 23 is 1 and bit 22 is 0 (underrange), result_o[31:22] is all ones and result_o[21:0] is the data.
- R8: When bits 23 and 22 are both 1 (including the all-ones stuck word), err_o pulses instead of valid_o and result_o keeps its previous value.
- R9: After reset the block runs two complete conversions without a request. The second start pulse follows the first read after a single chip-select-high cycle. No valid_o or err_o appears during these runs. ready_o rises once they finish and stays high.
- R10: valid_o and err_o are single-cycle pulses, given in the cycle right after the last read bit. result_o changes only together with valid_o.
- R11: A start request is ignored while busy_o is high. This covers the startup runs and any conversion in progress. Such a request launches no extra conversion and does not change the timing of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken when idle and ready |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idle level set by CPOL |
| csn_o | output | 1 | Active-low chip select |
| result_o | output | 32 | Signed decoded result |
| valid_o | output | 1 | One-cycle pulse: result_o updated |
| err_o | output | 1 | One-cycle pulse: impossible code received |
| ready_o | output | 1 | Startup recovery finished |
| busy_o | output | 1 | A sequence is in progress |

## Verification
A wrong sequencer state appears first on csn_o. A pulse or wait counter that is off by one moves the first read edge and changes the number of low and high cycles. A bad bit counter changes the rising-edge count before chip select goes high. Decode faults show in the result word of the same conversion, one cycle after the last bit. A faulty recovery counter shows as early or missing ready_o, or as a result pulse leaking out of the startup runs, long before the first requested conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_PULSE,
      ST_WAIT,
      ST_READ,
      ST_REL
   } seq_state_e;

   localparam int unsigned DATA_W = 24;
   localparam int unsigned OUT_W  = 32;

   function automatic int unsigned frame_bits(input int unsigned cpol);
      return (cpol != 0) ? 24 : 25;
   endfunction

endpackage

// File: rtl/dsadc_timer.sv
module dsadc_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dsadc_rx.sv
module dsadc_rx #(
   parameter int unsigned CPOL      = 0,
   parameter int unsigned HALF      = 2,
   parameter int unsigned NBITS     = 25,
   parameter int unsigned DATA_W    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              done_o,
   output logic [DATA_W-1:0] word_o
);
   localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int unsigned BW = $clog2(NBITS);

   logic [HW-1:0]     hcnt_q;
   logic [BW-1:0]     bcnt_q;
   logic              phase_q;
   logic [DATA_W-1:0] sh_q;
   logic              half_end;

   assign half_end = (hcnt_q == HW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q  <= '0;
         bcnt_q  <= '0;
         phase_q <= 1'b0;
         sh_q    <= '0;
      end else if (!en_i) begin
         hcnt_q  <= '0;
         bcnt_q  <= '0;
         phase_q <= 1'b0;
      end else if (half_end) begin
         hcnt_q <= '0;
         if (!phase_q) begin
            phase_q <= 1'b1;
            sh_q    <= {sh_q[DATA_W-2:0], miso_i};
         end else begin
            phase_q <= 1'b0;
            bcnt_q  <= bcnt_q + 1'b1;
         end
      end else begin
         hcnt_q <= hcnt_q + 1'b1;
      end
   end

   assign done_o = en_i && phase_q && half_end && (bcnt_q == BW'(NBITS - 1));
   assign word_o = sh_q;

   generate
      if (CPOL != 0) begin : g_idle_high
         assign sclk_o = en_i ? phase_q : 1'b1;
      end else begin : g_idle_low
         assign sclk_o = en_i ? phase_q : 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dsadc_decode.sv
module dsadc_decode #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned OUT_W  = 32
) (
   input  logic [DATA_W-1:0] word_i,
   output logic [OUT_W-1:0]  value_o,
   output logic              bad_o
);
   localparam int unsigned MAG_W = DATA_W - 2;
   localparam int unsigned EXT_W = OUT_W - MAG_W;

   logic under_f, over_f, sgn_f, fill;

   assign under_f = word_i[DATA_W-1];
   assign over_f  = word_i[DATA_W-2];
   assign sgn_f   = word_i[DATA_W-3];

   always_comb begin
      bad_o = under_f && over_f;
      if (over_f)
         fill = 1'b0;
      else
         fill = under_f || sgn_f;
      value_o = {{EXT_W{fill}}, word_i[MAG_W-1:0]};
   end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
   import dsadc_pkg::*;
#(
   parameter int unsigned CONV_CYCLES     = 20_750_000,
   parameter int unsigned CS_PULSE_CYCLES = 2000,
   parameter int unsigned CPOL            = 0,
   parameter int unsigned SCLK_HALF       = 25,
   parameter int unsigned RECOVERY_RUNS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              csn_o,
   output logic [OUT_W-1:0]  result_o,
   output logic              valid_o,
   output logic              err_o,
   output logic              ready_o,
   output logic              busy_o
);
   localparam int unsigned NBITS = frame_bits(CPOL);
   localparam int unsigned TMAX  = (CONV_CYCLES > CS_PULSE_CYCLES) ? CONV_CYCLES : CS_PULSE_CYCLES;
   localparam int unsigned TW    = $clog2(TMAX + 1);
   localparam int unsigned RW    = $clog2(RECOVERY_RUNS + 1);

   generate
      if (CPOL > 1) begin : g_bad_cpol
         $error("CPOL must be 0 or 1");
      end
      if (CONV_CYCLES < 1 || CS_PULSE_CYCLES < 1) begin : g_bad_time
         $error("pulse and conversion times must be at least one cycle");
      end
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("SCLK_HALF must be at least one");
      end
      if (RECOVERY_RUNS < 1) begin : g_bad_recov
         $error("RECOVERY_RUNS must be at least one");
      end
   endgenerate

   seq_state_e        state_q;
   logic [RW-1:0]     recov_q;
   logic              t_load, t_zero;
   logic [TW-1:0]     t_val;
   logic              rx_en, rx_done;
   logic [DATA_W-1:0] rx_word;
   logic [OUT_W-1:0]  dec_val;
   logic              dec_bad;
   logic              report;
   logic              restart;

   assign restart = (state_q == ST_REL) && (recov_q > RW'(1));
   assign report  = rx_done && (recov_q == '0);
   assign rx_en   = (state_q == ST_READ);

   always_comb begin
      t_load = 1'b0;
      t_val  = TW'(CS_PULSE_CYCLES - 1);
      if (state_q == ST_BOOT || restart || (state_q == ST_IDLE && start_i)) begin
         t_load = 1'b1;
      end else if (state_q == ST_PULSE && t_zero) begin
         t_load = 1'b1;
         t_val  = TW'(CONV_CYCLES - 1);
      end
   end

   dsadc_timer #(.W(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .zero_o     (t_zero)
   );

   dsadc_rx #(.CPOL(CPOL), .HALF(SCLK_HALF), .NBITS(NBITS), .DATA_W(DATA_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (rx_en),
      .miso_i (miso_i),
      .sclk_o (sclk_o),
      .done_o (rx_done),
      .word_o (rx_word)
   );

   dsadc_decode #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_dec (
      .word_i  (rx_word),
      .value_o (dec_val),
      .bad_o   (dec_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_BOOT;
         recov_q  <= RW'(RECOVERY_RUNS);
         valid_o  <= 1'b0;
         err_o    <= 1'b0;
         result_o <= '0;
      end else begin
         valid_o <= report && !dec_bad;
         err_o   <= report && dec_bad;
         if (report && !dec_bad)
            result_o <= dec_val;
         unique case (state_q)
            ST_BOOT:  state_q <= ST_PULSE;
            ST_IDLE:  if (start_i) state_q <= ST_PULSE;
            ST_PULSE: if (t_zero) state_q <= ST_WAIT;
            ST_WAIT:  if (t_zero) state_q <= ST_READ;
            ST_READ:  if (rx_done) state_q <= ST_REL;
            ST_REL: begin
               state_q <= restart ? ST_PULSE : ST_IDLE;
               if (recov_q != '0)
                  recov_q <= recov_q - 1'b1;
            end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign csn_o   = !(state_q == ST_PULSE || state_q == ST_READ);
   assign busy_o  = (state_q != ST_IDLE);
   assign ready_o = (recov_q == '0);
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
   parameter int unsigned CPOL = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        sclk_o,
   input logic        csn_o,
   input logic [31:0] result_o,
   input logic        valid_o,
   input logic        err_o,
   input logic        ready_o,
   input logic        busy_o
);
   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      csn_o |-> (sclk_o == CPOL[0])); // R3
   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> csn_o); // R2
   AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && err_o)); // R8
   AST_QUIET_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> (!valid_o && !err_o)); // R9
   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o); // R9
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R10
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R10
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(result_o)); // R10
   AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !csn_o |-> busy_o); // R11
endmodule

bind dsadc_seq dsadc_seq_chk #(.CPOL(CPOL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk_o   (sclk_o),
   .csn_o    (csn_o),
   .result_o (result_o),
   .valid_o  (valid_o),
   .err_o    (err_o),
   .ready_o  (ready_o),
   .busy_o   (busy_o)
);

// File: tb/sim_dsadc_seq.sv
`timescale 1ns/1ps
module sim_adc_model #(
   parameter int NB = 25
) (
   input  logic        csn_i,
   input  logic        sclk_i,
   input  logic [24:0] word_i,
   output logic        miso_o,
   output int          edges_o
);
   int rises = 0;
   int base  = 0;
   always @(posedge sclk_i) if (!csn_i) rises = rises + 1;
   always @(negedge csn_i) base = rises;
   assign edges_o = rises - base;
   assign miso_o  = (edges_o < NB) ? word_i[NB-1-edges_o] : 1'b0;
endmodule

module sim_dsadc_seq;
   localparam int P = 4;
   localparam int C = 20;
   localparam int H = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        start [2];
   logic        miso  [2];
   logic        sclk  [2];
   logic        csn   [2];
   logic        valid [2];
   logic        err   [2];
   logic        ready [2];
   logic        busy  [2];
   logic [31:0] res   [2];
   logic [24:0] word  [2];
   int          edges [2];
   logic [31:0] last_good [2];

   int n_cmp = 0;
   int n_bad = 0;
   int cyc_all = 0;
   int falls0 = 0;
   int falls1 = 0;
   int pulses0 = 0;
   int pulses1 = 0;

   dsadc_seq #(.CONV_CYCLES(C), .CS_PULSE_CYCLES(P), .CPOL(0), .SCLK_HALF(H)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start[0]), .miso_i(miso[0]),
      .sclk_o(sclk[0]), .csn_o(csn[0]), .result_o(res[0]), .valid_o(valid[0]),
      .err_o(err[0]), .ready_o(ready[0]), .busy_o(busy[0]));

   dsadc_seq #(.CONV_CYCLES(C), .CS_PULSE_CYCLES(P), .CPOL(1), .SCLK_HALF(H)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start[1]), .miso_i(miso[1]),
      .sclk_o(sclk[1]), .csn_o(csn[1]), .result_o(res[1]), .valid_o(valid[1]),
      .err_o(err[1]), .ready_o(ready[1]), .busy_o(busy[1]));

   sim_adc_model #(.NB(25)) m0 (.csn_i(csn[0]), .sclk_i(sclk[0]), .word_i(word[0]),
      .miso_o(miso[0]), .edges_o(edges[0]));
   sim_adc_model #(.NB(24)) m1 (.csn_i(csn[1]), .sclk_i(sclk[1]), .word_i(word[1]),
      .miso_o(miso[1]), .edges_o(edges[1]));

   always @(negedge csn[0]) falls0 = falls0 + 1;
   always @(negedge csn[1]) falls1 = falls1 + 1;
   always @(negedge clk) begin
      if (valid[0] || err[0]) pulses0 = pulses0 + 1;
      if (valid[1] || err[1]) pulses1 = pulses1 + 1;
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cyc_all = cyc_all + 1;
      if (cyc_all > 150000) begin
         n_cmp = n_cmp + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc_all);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp = n_cmp + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_conv(input int i, input logic [23:0] d, input logic flag, input bit poke);
      int nb    = (i == 0) ? 25 : 24;
      int lowc  = 0;
      int highc = 0;
      int wt    = 0;
      bit e_bad;
      logic [31:0] e_val;
      string tag;
      word[i] = {flag, d};
      @(negedge clk); start[i] = 1'b1;
      @(negedge clk); start[i] = 1'b0;
      while (csn[i] == 1'b0 && lowc < 1000) begin
         lowc++;
         @(negedge clk);
      end
      while (csn[i] == 1'b1 && highc < 1000) begin
         highc++;
         start[i] = (poke && highc == 3);
         @(negedge clk);
      end
      start[i] = 1'b0;
      check(lowc == P, "R2 start pulse width", lowc, P);
      check(highc == C, "R2 conversion wait", highc, C);
      while (!valid[i] && !err[i] && wt < 2000) begin
         wt++;
         if (poke && wt == 5) start[i] = 1'b1; else start[i] = 1'b0;
         @(negedge clk);
      end
      start[i] = 1'b0;
      check(wt == nb * 2 * H, "R3 read duration", wt, nb * 2 * H);
      check(edges[i] == nb, "R3 rising edge count", edges[i], nb);
      check(csn[i] == 1'b1 && sclk[i] == i[0], "R3 lines parked", {csn[i], sclk[i]}, {1'b1, i[0]});
      e_bad = d[23] && d[22];
      if (d[22]) e_val = {10'h000, d[21:0]};
      else if (d[23] || d[21]) e_val = {10'h3FF, d[21:0]};
      else e_val = {10'h000, d[21:0]};
      tag = e_bad ? "R8" : (d[22] ? "R6" : (d[23] ? "R7" : "R5"));
      if (e_bad) begin
         check(err[i] && !valid[i], "R8 error pulse", {valid[i], err[i]}, 2'b01);
         check(res[i] == last_good[i], "R8 result held", res[i], last_good[i]);
      end else begin
         check(valid[i] && !err[i], {tag, " valid pulse"}, {valid[i], err[i]}, 2'b10);
         check(res[i] == e_val, {tag, " R4 decoded value"}, res[i], e_val);
         last_good[i] = e_val;
      end
      @(negedge clk);
      check(!valid[i] && !err[i], "R10 single-cycle pulse", {valid[i], err[i]}, 2'b00);
      check(!busy[i], "R11 back to idle", busy[i], 1'b0);
      if (poke) begin
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (csn[i] == 1'b0 || busy[i]) begin
               check(1'b0, "R11 ignored start launched a conversion", {csn[i], busy[i]}, 2'b10);
               break;
            end
         end
      end
   endtask

   initial begin
      int cyc = 0;
      int rdy_at [2];
      int exp0, exp1;
      logic [20:0] lows [4];
      rst_n = 1'b0;
      start[0] = 1'b0;
      start[1] = 1'b0;
      word[0] = 25'h1FFFFFF;
      word[1] = 25'h0FFFFFF;
      last_good[0] = '0;
      last_good[1] = '0;
      rdy_at[0] = -1;
      rdy_at[1] = -1;
      lows[0] = 21'h000000;
      lows[1] = 21'h1FFFFF;
      lows[2] = 21'h0AAAAA;
      lows[3] = 21'h15A5A3;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         check(csn[i] == 1'b1 && sclk[i] == i[0], "R1 reset lines", {csn[i], sclk[i]}, {1'b1, i[0]});
         check(!valid[i] && !err[i] && !ready[i], "R1 reset outputs", {valid[i], err[i], ready[i]}, 3'b000);
         check(res[i] == 32'h0, "R1 reset result", res[i], 32'h0);
      end
      falls0 = 0;
      falls1 = 0;
      pulses0 = 0;
      pulses1 = 0;
      rst_n = 1'b1;
      while ((rdy_at[0] < 0 || rdy_at[1] < 0) && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         start[0] = (cyc == 10) || (cyc == 60);
         start[1] = (cyc == 30);
         if (rdy_at[0] < 0 && ready[0]) rdy_at[0] = cyc;
         if (rdy_at[1] < 0 && ready[1]) rdy_at[1] = cyc;
      end
      start[0] = 1'b0;
      start[1] = 1'b0;
      exp0 = 1 + 2 * (P + C + 25 * 2 * H + 1);
      exp1 = 1 + 2 * (P + C + 24 * 2 * H + 1);
      check(rdy_at[0] == exp0, "R9 ready time CPOL0 (R11 startup start ignored)", rdy_at[0], exp0);
      check(rdy_at[1] == exp1, "R9 ready time CPOL1", rdy_at[1], exp1);
      repeat (20) @(negedge clk);
      check(falls0 == 4, "R9 startup select count CPOL0", falls0, 4);
      check(falls1 == 4, "R9 startup select count CPOL1", falls1, 4);
      check(pulses0 == 0 && pulses1 == 0, "R9 startup outputs suppressed", pulses0 + pulses1, 0);
      check(ready[0] && ready[1], "R9 ready held", {ready[0], ready[1]}, 2'b11);
      check(!busy[0] && !busy[1] && csn[0] && csn[1], "R2 idle deselected", {busy[0], busy[1]}, 2'b00);

      for (int i = 0; i < 2; i++) begin
         for (int hi = 0; hi < 8; hi++) begin
            for (int lo = 0; lo < 4; lo++) begin
               run_conv(i, {hi[2:0], lows[lo]}, hi[0] ^ lo[0], 1'b0);
            end
         end
         run_conv(i, 24'h3FFFFF, 1'b1, 1'b1);
         run_conv(i, 24'hFFFFFF, 1'b1, 1'b0);
         run_conv(i, 24'h800001, 1'b0, 1'b1);
      end
      summary();
      $finish;
   end
endmodule